// File: doc/BRIEF.md
# Global Instruction-Cache Invalidate Controller

This block carries out a bulk instruction-cache invalidate in a small multi-core cluster. The issuing pipeline hands it a decoded invalidate request. The request carries the 5-bit register-specifier field, the register value, a 2-bit capability code and the coprocessor-0 usable flag. The block first checks the capability code and the coprocessor-0 flag and raises the matching exception when a check fails. Otherwise it starts a full sweep of the local cache, sends invalidate messages to remote cores, or does both. A zero register field means broadcast: every remote core receives a message and the local cache is also swept. Any other field value picks one core, named by the low bits of the register value, and that core may be the local one.

The local sweep clears one set per clock and leaves locked ways untouched. Remote messages go out over a request/acknowledge channel, one at a time. A message is held until the ordering point acknowledges it, and only then may the next one leave. An internal count of outstanding work grows when a sweep or message starts and shrinks when it finishes. A later fence request with subtype 0x14 completes only when that count is zero. Fences with any other subtype complete at once.

The control path has three states: `C_IDLE` (takes a request), `C_FAULT_RI` (reserved-instruction pulse) and `C_FAULT_CPU` (coprocessor-unusable pulse). Transitions: from `C_IDLE` on an accepted request with capability bit 1 clear to `C_FAULT_RI`; from `C_IDLE` on an accepted request with capability bit 1 set and coprocessor 0 disabled to `C_FAULT_CPU`; from either fault state back to `C_IDLE` after one cycle. A good request launches its work directly from `C_IDLE`. The sweeper moves `W_IDLE`→`W_SWEEP` on launch and back after the last set. The sender moves `R_IDLE`→`R_SEND` on launch and back on the acknowledge of its last message. The fence moves `B_IDLE`→`B_WAIT` on a fence request and back when it signals done.

Top module: `ginv_ctrl`

## Requirements
- R1: A good request with register field 0 sweeps the local cache. It also sends exactly one message to every other core, in ascending core index, skipping the local core.
- R2: A good request with a non-zero register field and a low-bit target naming a remote core sends exactly one message to that core and does not sweep. Register-value bits above the target index have no effect.
- R3: A good request with a non-zero register field whose target names the local core sweeps the local cache and sends no message.
- R4: When capability bit 1 is clear, `exc_reserved` is high for exactly the one cycle after acceptance. No sweep and no message follow.
- R5: When capability bit 1 is set and `cop0_usable` is low, `exc_cop_unusable` is high for the one cycle after acceptance with `exc_cop_num` equal to 0. No sweep and no message follow.
- R6: A sweep asserts `sweep_en` for NUM_SETS consecutive cycles, starting the cycle after acceptance at set 0 and stepping the set by one each cycle. It never clears a way that is flagged in `sweep_lock`, and it clears every other way.
- R7: `rinv_req` stays high with a stable `rinv_target` until `rinv_ack`. A further message is raised only after the previous one was acknowledged, and never to the local core.
- R8: A fence with subtype 0x14 raises `bar_done` only after every earlier sweep has ended and every earlier message has been acknowledged.
- R9: A fence with any other subtype raises `bar_done` in the cycle after it is taken, even while a sweep is running.
- R10: `inv_ready` is low while a sweep runs, a message is in flight or an exception is signalled. `busy` is high exactly while the sweep runs.
- R11: With NUM_CORES set to 1, every good request sweeps the local cache and `rinv_req` never rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| inv_valid | input | 1 | Invalidate request present |
| inv_ready | output | 1 | Block can take a request |
| inv_rs_field | input | 5 | Register-specifier field of the request |
| inv_rs_data | input | XLEN | Value of the selected register |
| cap_level | input | 2 | Capability code; bit 1 set means supported |
| cop0_usable | input | 1 | Coprocessor 0 access enabled |
| exc_reserved | output | 1 | Reserved-instruction exception pulse |
| exc_cop_unusable | output | 1 | Coprocessor-unusable exception pulse |
| exc_cop_num | output | 2 | Coprocessor number for the unusable exception |
| busy | output | 1 | Local sweep in progress |
| sweep_en | output | 1 | Write strobe to the tag array this cycle |
| sweep_set | output | SET_W | Set being cleared |
| sweep_clear | output | NUM_WAYS | Ways whose valid bit is cleared |
| sweep_lock | input | NUM_WAYS | Lock flags of the addressed set |
| rinv_req | output | 1 | Remote invalidate message request |
| rinv_target | output | CORE_W | Destination core of the message |
| rinv_ack | input | 1 | Ordering point accepted the message |
| bar_valid | input | 1 | Fence request, held until done |
| bar_stype | input | 5 | Fence subtype |
| bar_done | output | 1 | Fence complete |

## Verification
Bad state in the outstanding counter shows up only at a 0x14 fence. A count that lags lets `bar_done` rise while `busy` or `rinv_req` is still high, or before the last acknowledge is logged. A count that leaks holds the fence forever, and the next fence after the faulty request exposes it. A wrong sweep index or lock mask is seen in the bench's tag model once the sweep ends, within NUM_SETS cycles. A wrong broadcast order, a skipped core or a message to the local core is seen in the remote message log at the fence that follows. An error in the exception path shows in the cycle after acceptance.

// File: rtl/ginv_pkg.sv
package ginv_pkg;

    typedef enum logic [1:0] {
        C_IDLE,
        C_FAULT_RI,
        C_FAULT_CPU
    } ctrl_state_e;

    typedef enum logic {
        W_IDLE,
        W_SWEEP
    } walk_state_e;

    typedef enum logic {
        R_IDLE,
        R_SEND
    } rmt_state_e;

    typedef enum logic {
        B_IDLE,
        B_WAIT
    } fence_state_e;

    localparam int          RS_W       = 5;
    localparam int          STYPE_W    = 5;
    localparam logic [4:0]  STYPE_GINV = 5'h14;

endpackage

// File: rtl/ginv_sweeper.sv
module ginv_sweeper
    import ginv_pkg::*;
#(
    parameter int NUM_SETS = 64,
    parameter int NUM_WAYS = 4,
    parameter int SET_W    = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [NUM_WAYS-1:0] lock,
    output logic                en,
    output logic [SET_W-1:0]    set_idx,
    output logic [NUM_WAYS-1:0] clear,
    output logic                sweeping,
    output logic                end_evt
);

    localparam logic [SET_W-1:0] LAST_SET = SET_W'(NUM_SETS - 1);

    walk_state_e      state_q, state_d;
    logic [SET_W-1:0] set_q;
    logic             at_last;

    assign at_last = (set_q == LAST_SET);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= W_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            W_IDLE:  if (start)   state_d = W_SWEEP;
            W_SWEEP: if (at_last) state_d = W_IDLE;
            default:              state_d = W_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 set_q <= '0;
        else if (state_q == W_IDLE) set_q <= '0;
        else                        set_q <= set_q + SET_W'(1);
    end

    always_comb begin
        en       = 1'b0;
        clear    = '0;
        sweeping = 1'b0;
        end_evt  = 1'b0;
        unique case (state_q)
            W_IDLE: ;
            W_SWEEP: begin
                en       = 1'b1;
                clear    = ~lock;
                sweeping = 1'b1;
                end_evt  = at_last;
            end
            default: ;
        endcase
    end

    assign set_idx = set_q;

endmodule

// File: rtl/ginv_remote.sv
module ginv_remote
    import ginv_pkg::*;
#(
    parameter int NUM_CORES = 4,
    parameter int LOCAL_ID  = 0,
    parameter int CORE_W    = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              bcast,
    input  logic [CORE_W-1:0] tgt,
    input  logic              ack,
    output logic              req,
    output logic [CORE_W-1:0] target,
    output logic              sending,
    output logic              send_evt,
    output logic              ack_evt
);

    localparam logic [CORE_W:0] LOCAL_V = LOCAL_ID[CORE_W:0];
    localparam logic [CORE_W:0] COUNT_V = NUM_CORES[CORE_W:0];
    localparam logic [CORE_W:0] FIRST_V = (LOCAL_ID == 0) ? 1 : 0;

    // Step to the following core index, hopping over the local core.
    function automatic logic [CORE_W:0] step_core(input logic [CORE_W:0] cur);
        logic [CORE_W:0] n;
        n = cur + 1'b1;
        if (n == LOCAL_V) n = n + 1'b1;
        return n;
    endfunction

    rmt_state_e        state_q, state_d;
    logic [CORE_W-1:0] tgt_q;
    logic              bcast_q;
    logic [CORE_W:0]   nxt_core;
    logic              more;

    assign nxt_core = step_core({1'b0, tgt_q});
    assign more     = bcast_q && (nxt_core < COUNT_V);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= R_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            R_IDLE: if (start)        state_d = R_SEND;
            R_SEND: if (ack && !more) state_d = R_IDLE;
            default:                  state_d = R_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tgt_q   <= '0;
            bcast_q <= 1'b0;
        end else if (state_q == R_IDLE && start) begin
            tgt_q   <= bcast ? FIRST_V[CORE_W-1:0] : tgt;
            bcast_q <= bcast;
        end else if (state_q == R_SEND && ack && more) begin
            tgt_q   <= nxt_core[CORE_W-1:0];
        end
    end

    always_comb begin
        req      = 1'b0;
        sending  = 1'b0;
        send_evt = 1'b0;
        ack_evt  = 1'b0;
        unique case (state_q)
            R_IDLE: send_evt = start;
            R_SEND: begin
                req      = 1'b1;
                sending  = 1'b1;
                ack_evt  = ack;
                send_evt = ack && more;
            end
            default: ;
        endcase
    end

    assign target = tgt_q;

endmodule

// File: rtl/ginv_fence.sv
module ginv_fence
    import ginv_pkg::*;
#(
    parameter int CNT_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               walk_inc,
    input  logic               send_inc,
    input  logic               walk_dec,
    input  logic               ack_dec,
    input  logic               bar_valid,
    input  logic [STYPE_W-1:0] bar_stype,
    output logic               bar_done
);

    fence_state_e       state_q, state_d;
    logic [CNT_W-1:0]   pend_q;
    logic [STYPE_W-1:0] stype_q;
    logic               drained;
    logic               ready_to_close;

    assign drained        = (pend_q == '0);
    assign ready_to_close = (stype_q != STYPE_GINV) || drained;

    // Outstanding work: sweeps and messages in flight.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_q + CNT_W'(walk_inc) + CNT_W'(send_inc)
                                     - CNT_W'(walk_dec) - CNT_W'(ack_dec);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= B_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            B_IDLE: if (bar_valid)      state_d = B_WAIT;
            B_WAIT: if (ready_to_close) state_d = B_IDLE;
            default:                    state_d = B_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                              stype_q <= '0;
        else if (state_q == B_IDLE && bar_valid) stype_q <= bar_stype;
    end

    always_comb begin
        bar_done = 1'b0;
        unique case (state_q)
            B_IDLE: ;
            B_WAIT: bar_done = ready_to_close;
            default: ;
        endcase
    end

endmodule

// File: rtl/ginv_ctrl.sv
module ginv_ctrl
    import ginv_pkg::*;
#(
    parameter int NUM_CORES = 4,
    parameter int LOCAL_ID  = 0,
    parameter int NUM_SETS  = 64,
    parameter int NUM_WAYS  = 4,
    parameter int XLEN      = 32,
    parameter int CORE_W    = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
    parameter int SET_W     = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                inv_valid,
    output logic                inv_ready,
    input  logic [RS_W-1:0]     inv_rs_field,
    input  logic [XLEN-1:0]     inv_rs_data,
    input  logic [1:0]          cap_level,
    input  logic                cop0_usable,
    output logic                exc_reserved,
    output logic                exc_cop_unusable,
    output logic [1:0]          exc_cop_num,
    output logic                busy,
    output logic                sweep_en,
    output logic [SET_W-1:0]    sweep_set,
    output logic [NUM_WAYS-1:0] sweep_clear,
    input  logic [NUM_WAYS-1:0] sweep_lock,
    output logic                rinv_req,
    output logic [CORE_W-1:0]   rinv_target,
    input  logic                rinv_ack,
    input  logic                bar_valid,
    input  logic [STYPE_W-1:0]  bar_stype,
    output logic                bar_done
);

    localparam int              CNT_W   = $clog2(NUM_CORES + 3);
    localparam logic [CORE_W:0] COUNT_V = NUM_CORES[CORE_W:0];
    localparam logic [CORE_W:0] LOCAL_V = LOCAL_ID[CORE_W:0];

    ctrl_state_e       state_q, state_d;
    logic              accept;
    logic              is_bcast;
    logic [CORE_W-1:0] tgt;
    logic              tgt_local;
    logic              tgt_range;
    logic              bad_cap;
    logic              bad_cop;
    logic              launch;
    logic              walk_start;
    logic              rmt_start;
    logic              walk_busy;
    logic              walk_end;
    logic              rmt_busy;
    logic              send_evt;
    logic              ack_evt;
    logic              unused_hi;

    assign tgt       = inv_rs_data[CORE_W-1:0];
    assign unused_hi = ^inv_rs_data;
    assign is_bcast  = (inv_rs_field == '0);
    assign tgt_local = (NUM_CORES == 1) || ({1'b0, tgt} == LOCAL_V);
    assign tgt_range = ({1'b0, tgt} < COUNT_V);
    assign bad_cap   = !cap_level[1];
    assign bad_cop   = cap_level[1] && !cop0_usable;
    assign accept    = inv_valid && inv_ready;
    assign launch    = accept && !bad_cap && !bad_cop;

    // Control state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= C_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            C_IDLE: begin
                if (accept && bad_cap)      state_d = C_FAULT_RI;
                else if (accept && bad_cop) state_d = C_FAULT_CPU;
            end
            C_FAULT_RI:  state_d = C_IDLE;
            C_FAULT_CPU: state_d = C_IDLE;
            default:     state_d = C_IDLE;
        endcase
    end

    // Control outputs
    always_comb begin
        inv_ready        = 1'b0;
        exc_reserved     = 1'b0;
        exc_cop_unusable = 1'b0;
        exc_cop_num      = 2'd0;
        walk_start       = 1'b0;
        rmt_start        = 1'b0;
        unique case (state_q)
            C_IDLE: begin
                inv_ready  = !walk_busy && !rmt_busy;
                walk_start = launch && (is_bcast || tgt_local);
                rmt_start  = launch && (NUM_CORES > 1) &&
                             (is_bcast || (!tgt_local && tgt_range));
            end
            C_FAULT_RI:  exc_reserved     = 1'b1;
            C_FAULT_CPU: exc_cop_unusable = 1'b1;
            default: ;
        endcase
    end

    ginv_sweeper #(
        .NUM_SETS (NUM_SETS),
        .NUM_WAYS (NUM_WAYS),
        .SET_W    (SET_W)
    ) u_sweep (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (walk_start),
        .lock     (sweep_lock),
        .en       (sweep_en),
        .set_idx  (sweep_set),
        .clear    (sweep_clear),
        .sweeping (walk_busy),
        .end_evt  (walk_end)
    );

    generate
        if (NUM_CORES > 1) begin : g_remote
            ginv_remote #(
                .NUM_CORES (NUM_CORES),
                .LOCAL_ID  (LOCAL_ID),
                .CORE_W    (CORE_W)
            ) u_rmt (
                .clk      (clk),
                .rst_n    (rst_n),
                .start    (rmt_start),
                .bcast    (is_bcast),
                .tgt      (tgt),
                .ack      (rinv_ack),
                .req      (rinv_req),
                .target   (rinv_target),
                .sending  (rmt_busy),
                .send_evt (send_evt),
                .ack_evt  (ack_evt)
            );
        end else begin : g_solo
            logic unused_ack;
            assign unused_ack  = rinv_ack ^ rmt_start;
            assign rinv_req    = 1'b0;
            assign rinv_target = '0;
            assign rmt_busy    = 1'b0;
            assign send_evt    = 1'b0;
            assign ack_evt     = 1'b0;
        end
    endgenerate

    ginv_fence #(
        .CNT_W (CNT_W)
    ) u_fence (
        .clk       (clk),
        .rst_n     (rst_n),
        .walk_inc  (walk_start),
        .send_inc  (send_evt),
        .walk_dec  (walk_end),
        .ack_dec   (ack_evt),
        .bar_valid (bar_valid),
        .bar_stype (bar_stype),
        .bar_done  (bar_done)
    );

    assign busy = walk_busy;

endmodule

// File: rtl/ginv_ctrl_chk.sv
module ginv_ctrl_chk
    import ginv_pkg::*;
#(
    parameter int NUM_CORES = 4,
    parameter int LOCAL_ID  = 0,
    parameter int NUM_SETS  = 64,
    parameter int NUM_WAYS  = 4,
    parameter int XLEN      = 32,
    parameter int CORE_W    = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
    parameter int SET_W     = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1
) (
    input logic                clk,
    input logic                rst_n,
    input logic                inv_valid,
    input logic                inv_ready,
    input logic [RS_W-1:0]     inv_rs_field,
    input logic [XLEN-1:0]     inv_rs_data,
    input logic [1:0]          cap_level,
    input logic                cop0_usable,
    input logic                exc_reserved,
    input logic                exc_cop_unusable,
    input logic [1:0]          exc_cop_num,
    input logic                busy,
    input logic                sweep_en,
    input logic [SET_W-1:0]    sweep_set,
    input logic [NUM_WAYS-1:0] sweep_clear,
    input logic [NUM_WAYS-1:0] sweep_lock,
    input logic                rinv_req,
    input logic [CORE_W-1:0]   rinv_target,
    input logic                rinv_ack,
    input logic                bar_valid,
    input logic [STYPE_W-1:0]  bar_stype,
    input logic                bar_done
);

    localparam logic [SET_W-1:0]  LAST_SET = SET_W'(NUM_SETS - 1);
    localparam logic [CORE_W:0]   LOCAL_V  = LOCAL_ID[CORE_W:0];

    // R4
    exc_ri_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_reserved |-> !sweep_en && !rinv_req && !exc_cop_unusable);

    // R5
    exc_cpu_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_cop_unusable |-> !sweep_en && !rinv_req && exc_cop_num == 2'd0);

    // R6
    lock_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sweep_en |-> (sweep_clear & sweep_lock) == '0);

    // R6
    set_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sweep_en && sweep_set != LAST_SET |=>
            sweep_en && sweep_set == $past(sweep_set) + SET_W'(1));

    // R7
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rinv_req && !rinv_ack |=> rinv_req && $stable(rinv_target));

    // R7
    never_local_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rinv_req |-> {1'b0, rinv_target} != LOCAL_V);

    // R1
    bcast_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inv_valid && inv_ready && cap_level[1] && cop0_usable && inv_rs_field == '0
            |=> sweep_en && sweep_set == '0 && busy && !inv_ready);

    // R10
    busy_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy || rinv_req || exc_reserved || exc_cop_unusable) |-> !inv_ready);

    generate
        if (NUM_CORES == 1) begin : g_solo_chk
            // R11
            solo_no_msg_chk: assert property (@(posedge clk) disable iff (!rst_n)
                sweep_en |-> !rinv_req);
        end
    endgenerate

endmodule

bind ginv_ctrl ginv_ctrl_chk #(
    .NUM_CORES (NUM_CORES),
    .LOCAL_ID  (LOCAL_ID),
    .NUM_SETS  (NUM_SETS),
    .NUM_WAYS  (NUM_WAYS),
    .XLEN      (XLEN),
    .CORE_W    (CORE_W),
    .SET_W     (SET_W)
) u_chk (.*);

// File: tb/ginv_ctrl_tb.sv
`timescale 1ns/1ps
module ginv_ctrl_tb;
    import ginv_pkg::*;

    localparam int NC   = 4;
    localparam int LID  = 2;
    localparam int SETS = 16;
    localparam int WAYS = 4;
    localparam int XL   = 32;
    localparam int CW   = 2;
    localparam int SW   = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic            inv_valid = 1'b0;
    logic            inv_ready;
    logic [4:0]      inv_rs_field = '0;
    logic [XL-1:0]   inv_rs_data = '0;
    logic [1:0]      cap_level = 2'b10;
    logic            cop0_usable = 1'b1;
    logic            exc_reserved, exc_cop_unusable;
    logic [1:0]      exc_cop_num;
    logic            busy, sweep_en;
    logic [SW-1:0]   sweep_set;
    logic [WAYS-1:0] sweep_clear, sweep_lock;
    logic            rinv_req;
    logic [CW-1:0]   rinv_target;
    logic            rinv_ack;
    logic            bar_valid = 1'b0;
    logic [4:0]      bar_stype = '0;
    logic            bar_done;

    ginv_ctrl #(.NUM_CORES(NC), .LOCAL_ID(LID), .NUM_SETS(SETS),
                .NUM_WAYS(WAYS), .XLEN(XL)) u_dut (
        .clk(clk), .rst_n(rst_n), .inv_valid(inv_valid), .inv_ready(inv_ready),
        .inv_rs_field(inv_rs_field), .inv_rs_data(inv_rs_data),
        .cap_level(cap_level), .cop0_usable(cop0_usable),
        .exc_reserved(exc_reserved), .exc_cop_unusable(exc_cop_unusable),
        .exc_cop_num(exc_cop_num), .busy(busy), .sweep_en(sweep_en),
        .sweep_set(sweep_set), .sweep_clear(sweep_clear), .sweep_lock(sweep_lock),
        .rinv_req(rinv_req), .rinv_target(rinv_target), .rinv_ack(rinv_ack),
        .bar_valid(bar_valid), .bar_stype(bar_stype), .bar_done(bar_done));

    // Single-core instance
    logic          s_valid = 1'b0, s_ready;
    logic [4:0]    s_field = '0;
    logic          s_exr, s_exc, s_busy, s_en, s_rreq, s_done;
    logic [1:0]    s_num;
    logic [SW-1:0] s_set;
    logic [WAYS-1:0] s_clr;
    logic [0:0]    s_tgt;
    int            s_sweeps = 0;
    bit            s_rreq_seen = 1'b0;

    ginv_ctrl #(.NUM_CORES(1), .LOCAL_ID(0), .NUM_SETS(SETS),
                .NUM_WAYS(WAYS), .XLEN(XL)) u_dut_solo (
        .clk(clk), .rst_n(rst_n), .inv_valid(s_valid), .inv_ready(s_ready),
        .inv_rs_field(s_field), .inv_rs_data(32'h5),
        .cap_level(2'b11), .cop0_usable(1'b1),
        .exc_reserved(s_exr), .exc_cop_unusable(s_exc), .exc_cop_num(s_num),
        .busy(s_busy), .sweep_en(s_en), .sweep_set(s_set), .sweep_clear(s_clr),
        .sweep_lock('0), .rinv_req(s_rreq), .rinv_target(s_tgt), .rinv_ack(1'b0),
        .bar_valid(1'b0), .bar_stype(5'h0), .bar_done(s_done));

    always @(posedge clk) begin
        if (s_en) s_sweeps <= s_sweeps + 1;
        if (s_rreq) s_rreq_seen <= 1'b1;
    end

    // Tag-array model
    logic [WAYS-1:0] vld [SETS];
    logic [WAYS-1:0] lck [SETS];
    logic [WAYS-1:0] new_lck [SETS];
    logic            refill = 1'b0;
    assign sweep_lock = lck[sweep_set];

    always @(posedge clk) begin
        if (refill) begin
            for (int i = 0; i < SETS; i++) begin
                vld[i] <= '1;
                lck[i] <= new_lck[i];
            end
        end else if (sweep_en) begin
            vld[sweep_set] <= vld[sweep_set] & ~sweep_clear;
        end
    end

    // Remote ordering-point model
    int        msg_cnt [NC];
    int        ord [8];
    int        ord_n;
    int        dly;
    logic      clr_log = 1'b0;

    always @(posedge clk) begin
        if (!rst_n) begin
            rinv_ack <= 1'b0;
            dly      <= 0;
        end else if (rinv_ack) begin
            rinv_ack <= 1'b0;
            dly      <= int'($urandom % 4);
        end else if (rinv_req) begin
            if (dly == 0) rinv_ack <= 1'b1;
            else          dly <= dly - 1;
        end
        if (clr_log) begin
            for (int i = 0; i < NC; i++) msg_cnt[i] <= 0;
            ord_n <= 0;
        end else if (rinv_ack && rinv_req) begin
            msg_cnt[rinv_target] <= msg_cnt[rinv_target] + 1;
            if (ord_n < 8) ord[ord_n] <= int'(rinv_target);
            ord_n <= ord_n + 1;
        end
    end

    int  n_chk = 0;
    int  n_fail = 0;
    bit  finished = 1'b0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic bit exp_walk(input logic [4:0] f, input logic [31:0] d,
                                    input logic [1:0] cap, input logic cp0);
        if (!cap[1] || !cp0) return 1'b0;
        if (f == 5'd0) return 1'b1;
        return int'(d[CW-1:0]) == LID;
    endfunction

    function automatic logic [NC-1:0] exp_rmask(input logic [4:0] f, input logic [31:0] d,
                                                input logic [1:0] cap, input logic cp0);
        logic [NC-1:0] m;
        if (!cap[1] || !cp0) return '0;
        if (f == 5'd0) begin
            m = '1;
            m[LID] = 1'b0;
            return m;
        end
        if (int'(d[CW-1:0]) == LID) return '0;
        m = '0;
        m[d[CW-1:0]] = 1'b1;
        return m;
    endfunction

    task automatic fill_cache(input bit rnd_locks);
        for (int i = 0; i < SETS; i++)
            new_lck[i] = rnd_locks ? WAYS'($urandom) : '0;
        refill  = 1'b1;
        clr_log = 1'b1;
        @(negedge clk);
        refill  = 1'b0;
        clr_log = 1'b0;
    endtask

    task automatic send_req(input logic [4:0] f, input logic [31:0] d,
                            input logic [1:0] cap, input logic cp0);
        while (!inv_ready) @(negedge clk);
        inv_valid    = 1'b1;
        inv_rs_field = f;
        inv_rs_data  = d;
        cap_level    = cap;
        cop0_usable  = cp0;
        @(negedge clk);
        inv_valid    = 1'b0;
    endtask

    task automatic fence(input logic [4:0] st, output int cyc);
        bar_valid = 1'b1;
        bar_stype = st;
        cyc = 0;
        @(negedge clk);
        while (!bar_done && cyc < 5000) begin
            cyc++;
            @(negedge clk);
        end
        bar_valid = 1'b0;
    endtask

    // Compare tag model and message log with the expected outcome.
    task automatic check_result(input bit walk, input logic [NC-1:0] rmask, input string tag);
        int bad;
        bad = 0;
        for (int i = 0; i < SETS; i++) begin
            if (walk  && vld[i] != lck[i]) bad++;
            if (!walk && vld[i] != '1)     bad++;
        end
        chk(bad == 0, {tag, " tag array"}, bad, 0);
        for (int c = 0; c < NC; c++)
            chk(msg_cnt[c] == int'(rmask[c]), {tag, " messages"}, msg_cnt[c], int'(rmask[c]));
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : main
        int cyc;
        logic [4:0]  f;
        logic [31:0] d;
        logic [1:0]  cap;
        logic        cp0;
        int          bcyc;
        void'($urandom(32'd1234));
        for (int i = 0; i < SETS; i++) new_lck[i] = '0;
        refill = 1'b1;
        clr_log = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        refill = 1'b0;
        clr_log = 1'b0;
        @(negedge clk);

        // Reset state (R10)
        chk(inv_ready == 1'b1, "R10 reset ready", int'(inv_ready), 1);
        chk(busy == 1'b0 && rinv_req == 1'b0, "R10 reset idle", int'(busy), 0);
        chk(!exc_reserved && !exc_cop_unusable && !bar_done, "R4 reset quiet", int'(exc_reserved), 0);

        // R1 broadcast, R6 sweep length, R10 blocking
        fill_cache(1'b1);
        send_req(5'd0, 32'hDEAD_BEE0, 2'b10, 1'b1);
        chk(busy && !inv_ready, "R10 busy after launch", int'(inv_ready), 0);
        bcyc = 0;
        while (busy && bcyc < 100) begin bcyc++; @(negedge clk); end
        chk(bcyc == SETS, "R6 sweep cycles", bcyc, SETS);
        fence(STYPE_GINV, cyc);
        chk(!busy && !rinv_req, "R8 drained at fence", int'(rinv_req), 0);
        check_result(1'b1, exp_rmask(5'd0, 0, 2'b10, 1'b1), "R1");
        chk(ord_n == NC - 1, "R7 message count", ord_n, NC - 1);
        chk(ord[0] == 0 && ord[1] == 1 && ord[2] == 3, "R1 ascending order skip local",
            ord[2], 3);

        // R9 other subtype does not wait
        fill_cache(1'b0);
        send_req(5'd0, 32'h0, 2'b11, 1'b1);
        fence(5'h00, cyc);
        chk(cyc == 0, "R9 fence latency", cyc, 0);
        chk(busy == 1'b1, "R9 sweep still running", int'(busy), 1);
        fence(STYPE_GINV, cyc);
        chk(cyc >= SETS - 2, "R8 waited for sweep", cyc, SETS - 2);
        chk(!busy && ord_n == NC - 1, "R8 all acked", ord_n, NC - 1);
        @(negedge clk);

        // R2 single remote target with upper bits set
        fill_cache(1'b1);
        send_req(5'd7, 32'hFFFF_FFF3, 2'b10, 1'b1);
        chk(!busy, "R2 no sweep", int'(busy), 0);
        fence(STYPE_GINV, cyc);
        check_result(1'b0, 4'b1000, "R2");

        // R3 local target
        fill_cache(1'b1);
        send_req(5'd1, 32'h0000_0102, 2'b10, 1'b1);
        fence(STYPE_GINV, cyc);
        check_result(1'b1, 4'b0000, "R3");

        // R4 reserved instruction
        fill_cache(1'b0);
        send_req(5'd0, 32'h0, 2'b01, 1'b1);
        chk(exc_reserved && !exc_cop_unusable, "R4 pulse", int'(exc_reserved), 1);
        chk(!inv_ready, "R10 ready low in fault", int'(inv_ready), 0);
        @(negedge clk);
        chk(!exc_reserved, "R4 single cycle", int'(exc_reserved), 0);
        fence(STYPE_GINV, cyc);
        check_result(1'b0, 4'b0000, "R4");

        // R5 coprocessor unusable
        fill_cache(1'b0);
        send_req(5'd0, 32'h0, 2'b11, 1'b0);
        chk(exc_cop_unusable && exc_cop_num == 2'd0 && !exc_reserved, "R5 pulse",
            int'(exc_cop_unusable), 1);
        @(negedge clk);
        chk(!exc_cop_unusable, "R5 single cycle", int'(exc_cop_unusable), 0);
        fence(STYPE_GINV, cyc);
        check_result(1'b0, 4'b0000, "R5");

        // Random mix
        for (int it = 0; it < 60; it++) begin
            fill_cache(1'b1);
            f   = ($urandom % 3 == 0) ? 5'd0 : 5'(1 + $urandom % 31);
            d   = $urandom;
            cap = 2'($urandom);
            cp0 = ($urandom % 5) != 0;
            send_req(f, d, cap, cp0);
            chk(exc_reserved == !cap[1], "R4 random", int'(exc_reserved), int'(!cap[1]));
            chk(exc_cop_unusable == (cap[1] && !cp0), "R5 random",
                int'(exc_cop_unusable), int'(cap[1] && !cp0));
            fence(($urandom % 2) ? STYPE_GINV : 5'h03, cyc);
            if (bar_stype != STYPE_GINV) fence(STYPE_GINV, cyc);
            chk(!busy && !rinv_req, "R8 random drained", int'(busy), 0);
            check_result(exp_walk(f, d, cap, cp0), exp_rmask(f, d, cap, cp0), "R6 R7 random");
            @(negedge clk);
        end

        // R11 single-core instance
        s_field = 5'd0;
        s_valid = 1'b1;
        @(negedge clk);
        s_valid = 1'b0;
        while (!s_ready) @(negedge clk);
        s_field = 5'd3;
        s_valid = 1'b1;
        @(negedge clk);
        s_valid = 1'b0;
        while (!s_ready) @(negedge clk);
        chk(s_sweeps == 2 * SETS, "R11 sweeps", s_sweeps, 2 * SETS);
        chk(!s_rreq_seen, "R11 no message", int'(s_rreq_seen), 0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule